// File: doc/BRIEF.md
# Four-Channel Event Timer with Free-Running Timestamp Counter

This block is a memory-mapped timer with four countdown channels and one free-running up-counter. Each countdown channel has its own enable, its own one-shot or periodic mode and its own tick rate. It raises a one-clock interrupt pulse every time it expires. The up-counter is a 32-bit timestamp that software can read at any time. It advances on raw system clocks or on one of the derived ticks.

One shared timebase generator makes all the ticks. A divider of `CLK_MHZ` system clocks gives the 1 us tick. Three cascaded divide-by-ten stages give the 10 us, 100 us and 1 ms ticks. Software writes a 16-bit load value into a channel's timer register and then sets the channel's enable bit in the packed control register. The access port is a plain 32-bit register bus: one write strobe, a byte address and a combinational read path.

Top module: `tmr_block`

## Requirements
- R1: After reset, the control register reads 0, every channel count reads 0 and all interrupt outputs are low.
- R2: Control register layout at byte address 0x00:
  - bits 16..19 enable channels A, B, C, D;
  - bits 12..15 set the mode of channels A, B, C, D (1 = periodic, 0 = one-shot);
  - bits 10:8 hold the timestamp tick select;
  - bits 1:0, 3:2, 5:4 and 7:6 hold the tick selects of A, B, C and D.
  All other bits read 0.
- R3: Channel timer registers sit at byte addresses 0x04 (A), 0x08 (B), 0x0C (C) and 0x10 (D). A write sets both the running count and the reload value. A read returns the remaining count in bits 15:0.
- R4: Countdown tick select 0, 1, 2 and 3 give ticks of 1 us, 10 us, 100 us and 1 ms, where 1 us is `CLK_MHZ` system clocks.
- R5: In periodic mode, a load value N gives an interrupt every N+1 ticks, and the channel reloads N after each expiry.
- R6: In one-shot mode, a channel raises a single interrupt when it expires and clears its own enable bit in the control register.
- R7: Each expiry gives an interrupt pulse exactly one clock wide.
- R8: Clearing a channel's enable bit freezes its count at once, and no interrupt follows.
- R9: While enabled, a countdown channel's count drops by one on each selected tick.
- R10: The timestamp counter at byte address 0x14 increments by one on each selected tick and wraps modulo 2^32. Select 0 counts every system clock. Selects 1 to 4 count 1 us, 10 us, 100 us and 1 ms ticks. Selects 5 to 7 hold the value.
- R11: The timestamp register is read-only, and a bus write to 0x14 leaves its value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 4 | Per-channel expiry pulse, bit 0 = A |

## Verification
The hardest case to reach from the ports is a set of interrupt periods on the slow timebases. With the default clock ratio, a millisecond-tick channel takes tens of thousands of cycles per expiry. The bench therefore overrides `CLK_MHZ` to a small ratio and runs all four channels at once, each on a different timebase. A monitor then timestamps the interrupt pulses and compares the gap between the last two expiries of each channel against (N+1) times that channel's tick length. This measures the period independently of the tick phase that the channel had when it was enabled.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NCH    = 4;
    localparam int DATA_W = 32;
    localparam int LOAD_W = 16;
    localparam int ADDR_W = 5;
    localparam int NTB    = 4;

    // register index = byte address >> 2
    localparam logic [2:0] IDX_CTRL = 3'd0;
    localparam logic [2:0] IDX_TS   = 3'd5;

    typedef enum logic [1:0] {
        TB_1US   = 2'd0,
        TB_10US  = 2'd1,
        TB_100US = 2'd2,
        TB_1MS   = 2'd3
    } tb_sel_e;

    typedef struct packed {
        logic [NCH-1:0]      en;
        logic [NCH-1:0]      periodic;
        logic [2:0]          ts_sel;
        logic [NCH-1:0][1:0] sel;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] ctrl_pack(input ctrl_t c);
        return {12'd0, c.en, c.periodic, 1'b0, c.ts_sel, c.sel};
    endfunction

    function automatic ctrl_t ctrl_unpack(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.en       = w[19:16];
        c.periodic = w[15:12];
        c.ts_sel   = w[10:8];
        c.sel      = w[7:0];
        return c;
    endfunction

endpackage

// File: rtl/tmr_tickgen.sv
module tmr_tickgen #(
    parameter int CLK_MHZ = 50,
    parameter int NTB     = 4
) (
    input  logic           clk,
    input  logic           rst,
    output logic [NTB-1:0] tick
);
    localparam int US_W = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;

    logic [US_W-1:0] us_cnt;
    logic            us_tick;

    assign us_tick = (us_cnt == US_W'(CLK_MHZ - 1));

    always_ff @(posedge clk) begin
        if (rst || us_tick) us_cnt <= '0;
        else                us_cnt <= us_cnt + 1'b1;
    end

    assign tick[0] = us_tick;

    for (genvar k = 1; k < NTB; k++) begin : g_dec
        logic [3:0] dcnt;
        always_ff @(posedge clk) begin
            if (rst)
                dcnt <= '0;
            else if (tick[k-1])
                dcnt <= (dcnt == 4'd9) ? 4'd0 : dcnt + 4'd1;
        end
        assign tick[k] = tick[k-1] && (dcnt == 4'd9);
    end
endmodule

// File: rtl/tmr_down_chan.sv
module tmr_down_chan #(
    parameter int LOAD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              periodic,
    input  logic              tick,
    input  logic              load_wr,
    input  logic [LOAD_W-1:0] load_val,
    output logic [LOAD_W-1:0] count,
    output logic              done,
    output logic              irq
);
    logic [LOAD_W-1:0] reload_q;
    logic              expire;

    assign expire = en && tick && (count == '0);
    assign done   = expire && !periodic;

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            reload_q <= '0;
            irq      <= 1'b0;
        end else begin
            irq <= expire;
            if (load_wr) begin
                count    <= load_val;
                reload_q <= load_val;
            end else if (expire) begin
                if (periodic) count <= reload_q;
            end else if (en && tick) begin
                count <= count - 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr_ts_counter.sv
module tmr_ts_counter #(
    parameter int W   = 32,
    parameter int NTB = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [2:0]     sel,
    input  logic [NTB-1:0] tick,
    output logic [W-1:0]   value
);
    logic step;

    always_comb begin
        if (sel == 3'd0)                step = 1'b1;
        else if (int'(sel) <= NTB)      step = tick[sel - 3'd1];
        else                            step = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)       value <= '0;
        else if (step) value <= value + 1'b1;
    end
endmodule

// File: rtl/tmr_block.sv
module tmr_block
    import tmr_pkg::*;
#(
    parameter int CLK_MHZ = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    irq
);
    ctrl_t                   ctrl_q;
    logic [NTB-1:0]          ticks;
    logic [2:0]              idx;
    logic                    ctrl_wr;
    logic [NCH-1:0]          ld_wr;
    logic [NCH-1:0]          done;
    logic [NCH-1:0]          ch_tick;
    logic [NCH-1:0][LOAD_W-1:0] ch_count;
    logic [DATA_W-1:0]       ts_value;
    logic [NCH-1:0]          ch_en;
    logic [NCH-1:0]          ch_mode;
    logic [2:0]              ts_sel;

    assign idx     = bus_addr[4:2];
    assign ctrl_wr = bus_wr && (idx == IDX_CTRL);
    assign ch_en   = ctrl_q.en;
    assign ch_mode = ctrl_q.periodic;
    assign ts_sel  = ctrl_q.ts_sel;

    tmr_tickgen #(.CLK_MHZ(CLK_MHZ), .NTB(NTB)) u_tickgen (
        .clk (clk),
        .rst (rst),
        .tick(ticks)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign ld_wr[i]   = bus_wr && (idx == 3'(i + 1));
        assign ch_tick[i] = ticks[ctrl_q.sel[i]];

        tmr_down_chan #(.LOAD_W(LOAD_W)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .en      (ctrl_q.en[i]),
            .periodic(ctrl_q.periodic[i]),
            .tick    (ch_tick[i]),
            .load_wr (ld_wr[i]),
            .load_val(bus_wdata[LOAD_W-1:0]),
            .count   (ch_count[i]),
            .done    (done[i]),
            .irq     (irq[i])
        );
    end

    tmr_ts_counter #(.W(DATA_W), .NTB(NTB)) u_ts (
        .clk  (clk),
        .rst  (rst),
        .sel  (ctrl_q.ts_sel),
        .tick (ticks),
        .value(ts_value)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (ctrl_wr)
            ctrl_q <= ctrl_unpack(bus_wdata);
        else
            ctrl_q.en <= ctrl_q.en & ~done;
    end

    always_comb begin
        bus_rdata = '0;
        case (idx)
            IDX_CTRL: bus_rdata = ctrl_pack(ctrl_q);
            3'd1:     bus_rdata = DATA_W'(ch_count[0]);
            3'd2:     bus_rdata = DATA_W'(ch_count[1]);
            3'd3:     bus_rdata = DATA_W'(ch_count[2]);
            3'd4:     bus_rdata = DATA_W'(ch_count[3]);
            IDX_TS:   bus_rdata = ts_value;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_block_chk.sv
module tmr_block_chk #(
    parameter int NCH    = 4,
    parameter int LOAD_W = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       ctrl_wr,
    input logic [NCH-1:0]             ld_wr,
    input logic [NCH-1:0]             irq,
    input logic [NCH-1:0]             ch_en,
    input logic [NCH-1:0]             ch_mode,
    input logic [NCH-1:0][LOAD_W-1:0] ch_count,
    input logic [2:0]                 ts_sel,
    input logic [31:0]                ts_value
);
    for (genvar i = 0; i < NCH; i++) begin : g_a
        // R7
        irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
            irq[i] |=> !irq[i]);

        // R6
        oneshot_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (irq[i] && !ch_mode[i] && !$past(ctrl_wr)) |-> !ch_en[i]);

        // R8
        frozen_chk: assert property (@(posedge clk) disable iff (rst)
            (!ch_en[i] && !ld_wr[i]) |=> $stable(ch_count[i]));

        // R8
        irq_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
            irq[i] |-> $past(ch_en[i]));
    end

    // R10
    ts_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ts_sel == 3'd0) |=> (ts_value == $past(ts_value) + 32'd1));
endmodule

bind tmr_block tmr_block_chk #(.NCH(tmr_pkg::NCH), .LOAD_W(tmr_pkg::LOAD_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ctrl_wr (ctrl_wr),
    .ld_wr   (ld_wr),
    .irq     (irq),
    .ch_en   (ch_en),
    .ch_mode (ch_mode),
    .ch_count(ch_count),
    .ts_sel  (ts_sel),
    .ts_value(ts_value)
);

// File: tb/tmr_block_tb.sv
module tmr_block_tb;
    localparam int CLK_MHZ = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    int irq_cnt [4];
    int last_cyc[4];
    int intv    [4];
    logic [3:0] irq_prev;

    tmr_block #(.CLK_MHZ(CLK_MHZ)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        for (int i = 0; i < 4; i++) begin
            irq_cnt[i] = 0; last_cyc[i] = 0; intv[i] = 0;
        end
        irq_prev = '0;
    end

    // expiry monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < 4; i++) begin
                if (irq[i]) begin
                    if (irq_prev[i]) begin
                        n_bad++;
                        $display("FAIL R7 ch%0d irq high two cycles: actual 2 expected 1", i);
                    end
                    intv[i]     = cyc - last_cyc[i];
                    last_cyc[i] = cyc;
                    irq_cnt[i]++;
                end
            end
        end
        irq_prev = irq;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_irqs(input int ch, input int target, input int limit);
        for (int k = 0; k < limit && irq_cnt[ch] < target; k++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(5'h00, v); check("R1 ctrl", v, 32'h0);
        rd(5'h04, v); check("R1 countA", v, 32'h0);
        rd(5'h10, v); check("R1 countD", v, 32'h0);
        check("R1 irq", {28'd0, irq}, 32'h0);
    endtask

    task automatic t_ctrl_layout;
        logic [31:0] v;
        wr(5'h00, 32'hFFF0_FFFF);
        rd(5'h00, v); check("R2 readback", v, 32'h0000_F7FF);
        wr(5'h00, 32'h0);
        rd(5'h00, v); check("R2 cleared", v, 32'h0);
    endtask

    task automatic t_periodic;
        int base[4];
        int exp_iv[4] = '{10, 60, 400, 4000};
        wr(5'h04, 32'd4);
        wr(5'h08, 32'd2);
        wr(5'h0C, 32'd1);
        wr(5'h10, 32'd1);
        for (int i = 0; i < 4; i++) base[i] = irq_cnt[i];
        wr(5'h00, 32'h000F_F0E4);
        wait_irqs(3, base[3] + 3, 20000);
        for (int i = 0; i < 4; i++) begin
            check($sformatf("R5 ch%0d expiries", i), (irq_cnt[i] >= base[i] + 3) ? 1 : 0, 1);
            check($sformatf("R4 R5 ch%0d period", i), intv[i], exp_iv[i]);
        end
        wr(5'h00, 32'h0);
    endtask

    task automatic t_oneshot;
        logic [31:0] v;
        int base;
        wr(5'h04, 32'd3);
        base = irq_cnt[0];
        wr(5'h00, 32'h0001_0000);
        repeat (30) @(negedge clk);
        check("R6 single irq", irq_cnt[0] - base, 1);
        rd(5'h00, v); check("R6 enable self-cleared", v, 32'h0);
        rd(5'h04, v); check("R6 count at zero", v, 32'h0);
    endtask

    task automatic t_count_and_halt;
        logic [31:0] v1, v2;
        int base;
        wr(5'h04, 32'd200);
        wr(5'h00, 32'h0001_1000);
        repeat (5) @(negedge clk);
        rd(5'h04, v1);
        repeat (20) @(negedge clk);
        #1 v2 = bus_rdata;
        check("R9 R3 decrement over 10 ticks", v1 - v2, 32'd10);
        wr(5'h00, 32'h0000_1000);
        base = irq_cnt[0];
        rd(5'h04, v1);
        repeat (500) @(negedge clk);
        #1 v2 = bus_rdata;
        check("R8 count frozen", v2, v1);
        check("R8 no irq after disable", irq_cnt[0] - base, 0);
        wr(5'h00, 32'h0);
    endtask

    task automatic t_timestamp;
        logic [31:0] v1, v2;
        wr(5'h00, 32'h0000_0000);
        rd(5'h14, v1);
        repeat (10) @(negedge clk);
        #1 v2 = bus_rdata;
        check("R10 sysclk step", v2 - v1, 32'd10);
        wr(5'h00, 32'h0000_0100);
        rd(5'h14, v1);
        repeat (20) @(negedge clk);
        #1 v2 = bus_rdata;
        check("R10 1us step", v2 - v1, 32'd10);
        wr(5'h00, 32'h0000_0500);
        rd(5'h14, v1);
        wr(5'h14, 32'h1234_5678);
        rd(5'h14, v2);
        check("R11 write ignored", v2, v1);
        repeat (30) @(negedge clk);
        #1 v2 = bus_rdata;
        check("R10 select 5 holds", v2, v1);
        wr(5'h00, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ctrl_layout();
        t_periodic();
        t_oneshot();
        t_count_and_halt();
        t_timestamp();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule